// File: doc/BRIEF.md
# Radio Transceiver Power-State Sequencer

This block tracks the operating state of a low-rate 2.4 GHz personal-area-network radio and turns that state into a supply-current figure and a running charge total. A controller sends one strobe command per cycle on a three-bit code. The receive path reports frame start, frame end, acknowledge request and address rejection. The sequencer then steps through power-down, oscillator start-up, idle, the two calibrations, listening, frame receive, frame transmit and automatic acknowledge transmit. Each timed state holds for a cycle count derived from the bit period: symbol-based calibration, length-based frame airtime and a fixed acknowledge airtime.

The current of each state is given in tenths of a microampere. The three transmit states take their current from an eight-step output-power table. The power value is that current times the supply voltage. A saturating accumulator adds the current of each cycle, which gives charge in units of 0.1 µA·cycle for energy budgeting.

Top module: `rf_power_seq`

## Requirements
- R1: After reset the state code is 0 (power-down), the energy total is 0, `cmd_err` is 0 and the current code is 200.
- R2: Command code 1 (wake) in power-down enters start-up (state 1). Start-up lasts XOSC_CYC cycles and then enters idle (state 2). If `xosc_stable` is high in a start-up cycle, idle follows at the next edge.
- R3: Command code 3 (receive) in idle enters receive calibration (state 3). Calibration lasts 12·BITS_PER_SYM·CYC_PER_BIT cycles and then enters listening (state 4).
- R4: Command code 4 (transmit) in idle or listening, or code 5 (transmit after channel check) in listening with `cca_clear` high, enters transmit calibration (state 6). That lasts 12 symbols, then frame transmit (state 7) lasts (L+6)·8·CYC_PER_BIT cycles, where L is `frame_len` captured on entry to calibration. Listening follows. Code 5 with `cca_clear` low leaves listening unchanged without an error.
- R5: In listening, `rx_start` enters frame receive (state 5). In frame receive, `rx_addr_fail` or `rx_end` without `rx_ack_req` returns to listening. `rx_end` with `rx_ack_req` enters acknowledge transmit (state 8) for 88·CYC_PER_BIT cycles, then listening.
- R6: Command code 6 (off) in any state except power-down enters idle at the next edge and cuts any timed state short. In power-down it is illegal.
- R7: Command code 2 (sleep) in idle enters power-down.
- R8: Any other command/state pairing, including code 7, leaves the state unchanged. `cmd_err` is then high for exactly the cycle after the edge that sampled the command.
- R9: Current codes in 0.1 µA: power-down 200; start-up, idle and listening 4260; both receive-side active states 188000.
- R10: The transmit states use the table entry for the power level captured on entry to transmit calibration or acknowledge transmit: levels 0..7 give 174000, 165000, 152000, 139000, 125000, 112000, 99000, 85000.
- R11: `pwr_code` equals `cur_code`·SUPPLY_DV (0.01 µW units, SUPPLY_DV in decivolts, default 30).
- R12: Each edge adds the current code of the cycle to `energy`. The total saturates at all ones. `energy_clr` high at an edge loads zero instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command strobe code (0 none) |
| xosc_stable | input | 1 | Oscillator ready, ends start-up early |
| cca_clear | input | 1 | Channel found free |
| frame_len | input | LEN_W | Transmit frame length in bytes |
| pwr_level | input | 3 | Output power step, 0 is highest |
| rx_start | input | 1 | Incoming frame detected |
| rx_end | input | 1 | Incoming frame complete |
| rx_ack_req | input | 1 | Completed frame asks for acknowledge |
| rx_addr_fail | input | 1 | Incoming frame address rejected |
| energy_clr | input | 1 | Synchronous clear of the energy total |
| state_o | output | 4 | Current state code |
| cur_code | output | 18 | Current of the state, 0.1 µA |
| pwr_code | output | PWR_W | Power of the state, 0.01 µW |
| energy | output | ACC_W | Saturating charge total |
| cmd_err | output | 1 | Illegal-command pulse |

## Verification
The bench measures each dwell to the exact cycle: the oscillator wait, both calibrations, the acknowledge, and frame airtime at lengths 0, 5 and the maximum. An off-by-one timer load shows up as the state changing one edge early or late. It sweeps every command code in power-down and several busy states. A sequencer that accepts an illegal command changes state, and one that flags a legal command raises `cmd_err`. It changes `frame_len` and `pwr_level` after transmit entry, which exposes a design that reads them live instead of capturing them. It drives the accumulator into saturation, which exposes a total that wraps.

// File: rtl/rps_pkg.sv
package rps_pkg;

   localparam int CUR_W = 18;

   typedef enum logic [3:0] {
      RS_OFF    = 4'd0,
      RS_XOSC   = 4'd1,
      RS_IDLE   = 4'd2,
      RS_RXCAL  = 4'd3,
      RS_LISTEN = 4'd4,
      RS_RXFRM  = 4'd5,
      RS_TXCAL  = 4'd6,
      RS_TXFRM  = 4'd7,
      RS_TXACK  = 4'd8
   } rstate_e;

   typedef enum logic [2:0] {
      CMD_NONE  = 3'd0,
      CMD_WAKE  = 3'd1,
      CMD_SLEEP = 3'd2,
      CMD_RX    = 3'd3,
      CMD_TX    = 3'd4,
      CMD_TXCCA = 3'd5,
      CMD_OFF   = 3'd6,
      CMD_RSVD  = 3'd7
   } rcmd_e;

   // currents in tenths of a microampere
   localparam logic [CUR_W-1:0] I_SLEEP  = CUR_W'(200);
   localparam logic [CUR_W-1:0] I_QUIET  = CUR_W'(4260);
   localparam logic [CUR_W-1:0] I_RXBUSY = CUR_W'(188000);

   function automatic logic [CUR_W-1:0] tx_current(input logic [2:0] lvl);
      logic [CUR_W-1:0] r;
      case (lvl)
         3'd0: r = CUR_W'(174000);
         3'd1: r = CUR_W'(165000);
         3'd2: r = CUR_W'(152000);
         3'd3: r = CUR_W'(139000);
         3'd4: r = CUR_W'(125000);
         3'd5: r = CUR_W'(112000);
         3'd6: r = CUR_W'(99000);
         default: r = CUR_W'(85000);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rps_dwell_timer.sv
module rps_dwell_timer #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   if (W < 1) begin : g_bad_w
      $error("rps_dwell_timer: W must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // dwell counts down by one per cycle once loaded (R3, R4, R5)
   assert_tmr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt) != '0 && !$past(load)) |-> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rps_current_lut.sv
module rps_current_lut import rps_pkg::*; #(
   parameter int SUPPLY_DV = 30,
   parameter int PWR_W     = 23
) (
   input  rstate_e          st,
   input  logic [2:0]       lvl,
   output logic [CUR_W-1:0] cur,
   output logic [PWR_W-1:0] pwr
);

   if (PWR_W < CUR_W + $clog2(SUPPLY_DV + 1)) begin : g_bad_pwr
      $error("rps_current_lut: PWR_W too narrow for current times supply");
   end
   if (SUPPLY_DV < 1) begin : g_bad_sup
      $error("rps_current_lut: SUPPLY_DV must be positive");
   end

   logic [CUR_W-1:0] tx_tab [8];

   for (genvar i = 0; i < 8; i++) begin : g_tab
      assign tx_tab[i] = tx_current(3'(i));
   end

   always_comb begin
      case (st)
         RS_OFF:                        cur = I_SLEEP;
         RS_XOSC, RS_IDLE, RS_LISTEN:   cur = I_QUIET;
         RS_RXCAL, RS_RXFRM:            cur = I_RXBUSY;
         RS_TXCAL, RS_TXFRM, RS_TXACK:  cur = tx_tab[lvl];
         default:                       cur = I_SLEEP;
      endcase
   end

   assign pwr = PWR_W'(cur) * PWR_W'(SUPPLY_DV);

endmodule

// File: rtl/rps_energy_acc.sv
module rps_energy_acc #(
   parameter int ACC_W    = 48,
   parameter int IN_W     = 18,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [IN_W-1:0]  add,
   output logic [ACC_W-1:0] acc
);

   if (ACC_W <= IN_W) begin : g_bad_acc
      $error("rps_energy_acc: ACC_W must exceed IN_W");
   end

   logic [ACC_W:0] sum;
   assign sum = {1'b0, acc} + (ACC_W+1)'(add);

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)         acc <= '0;
         else if (clr)       acc <= '0;
         else if (sum[ACC_W]) acc <= '1;
         else                acc <= sum[ACC_W-1:0];
      end

      // a full total stays full until cleared (R12)
      assert_acc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(acc) == '1 && !$past(clr)) |-> (acc == '1));

      // never decreases except through clear (R12)
      assert_acc_monotonic_R12: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(clr) |-> (acc >= $past(acc)));
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)   acc <= '0;
         else if (clr) acc <= '0;
         else          acc <= sum[ACC_W-1:0];
      end
   end

   // clear wins over accumulation (R12)
   assert_acc_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (acc == '0));

endmodule

// File: rtl/rf_power_seq.sv
module rf_power_seq import rps_pkg::*; #(
   parameter int CYC_PER_BIT   = 4,
   parameter int BITS_PER_SYM  = 4,
   parameter int XOSC_CYC      = 250000,
   parameter int LEN_W         = 7,
   parameter int ACC_W         = 48,
   parameter int SUPPLY_DV     = 30,
   parameter int CAL_SYMS      = 12,
   parameter int TX_OVH_BYTES  = 6,
   parameter int ACK_BYTES     = 11,
   parameter bit ENERGY_SAT    = 1'b1,
   localparam int PWR_W        = CUR_W + $clog2(SUPPLY_DV + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cmd,
   input  logic             xosc_stable,
   input  logic             cca_clear,
   input  logic [LEN_W-1:0] frame_len,
   input  logic [2:0]       pwr_level,
   input  logic             rx_start,
   input  logic             rx_end,
   input  logic             rx_ack_req,
   input  logic             rx_addr_fail,
   input  logic             energy_clr,
   output logic [3:0]       state_o,
   output logic [CUR_W-1:0] cur_code,
   output logic [PWR_W-1:0] pwr_code,
   output logic [ACC_W-1:0] energy,
   output logic             cmd_err
);

   localparam int CAL_CYC = CAL_SYMS * BITS_PER_SYM * CYC_PER_BIT;
   localparam int ACK_CYC = ACK_BYTES * 8 * CYC_PER_BIT;
   localparam int FRM_MAX = ((1 << LEN_W) - 1 + TX_OVH_BYTES) * 8 * CYC_PER_BIT;
   localparam int D_A     = (CAL_CYC > ACK_CYC) ? CAL_CYC : ACK_CYC;
   localparam int D_B     = (D_A > FRM_MAX) ? D_A : FRM_MAX;
   localparam int D_MAX   = (D_B > XOSC_CYC) ? D_B : XOSC_CYC;
   localparam int TMR_W   = $clog2(D_MAX + 1);

   if (CYC_PER_BIT < 1 || BITS_PER_SYM < 1) begin : g_bad_rate
      $error("rf_power_seq: bit and symbol periods must be positive");
   end
   if (XOSC_CYC < 1 || CAL_SYMS < 1 || ACK_BYTES < 1) begin : g_bad_dwell
      $error("rf_power_seq: dwell counts must be positive");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("rf_power_seq: LEN_W out of range");
   end

   rstate_e          st, nxt;
   logic             illegal;
   logic             tmr_done;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic [LEN_W-1:0] len_q;
   logic [2:0]       lvl_q;
   rcmd_e            c;

   assign c = rcmd_e'(cmd);

   // next-state: events and dwell expiry first, a legal command overrides
   always_comb begin
      nxt     = st;
      illegal = 1'b0;
      case (st)
         RS_XOSC:   if (tmr_done || xosc_stable) nxt = RS_IDLE;
         RS_RXCAL:  if (tmr_done) nxt = RS_LISTEN;
         RS_LISTEN: if (rx_start) nxt = RS_RXFRM;
         RS_RXFRM: begin
            if (rx_addr_fail)               nxt = RS_LISTEN;
            else if (rx_end && rx_ack_req)  nxt = RS_TXACK;
            else if (rx_end)                nxt = RS_LISTEN;
         end
         RS_TXCAL:  if (tmr_done) nxt = RS_TXFRM;
         RS_TXFRM, RS_TXACK: if (tmr_done) nxt = RS_LISTEN;
         default: ;
      endcase

      case (c)
         CMD_NONE: ;
         CMD_WAKE: begin
            if (st == RS_OFF) nxt = RS_XOSC;
            else              illegal = 1'b1;
         end
         CMD_SLEEP: begin
            if (st == RS_IDLE) nxt = RS_OFF;
            else               illegal = 1'b1;
         end
         CMD_RX: begin
            if (st == RS_IDLE) nxt = RS_RXCAL;
            else               illegal = 1'b1;
         end
         CMD_TX: begin
            if (st == RS_IDLE || st == RS_LISTEN) nxt = RS_TXCAL;
            else                                  illegal = 1'b1;
         end
         CMD_TXCCA: begin
            if (st == RS_LISTEN) begin
               if (cca_clear) nxt = RS_TXCAL;
            end else begin
               illegal = 1'b1;
            end
         end
         CMD_OFF: begin
            if (st == RS_OFF) illegal = 1'b1;
            else              nxt = RS_IDLE;
         end
         default: illegal = 1'b1;
      endcase
   end

   // dwell length for the state being entered
   always_comb begin
      case (nxt)
         RS_XOSC:            tmr_val = TMR_W'(XOSC_CYC - 1);
         RS_RXCAL, RS_TXCAL: tmr_val = TMR_W'(CAL_CYC - 1);
         RS_TXFRM:           tmr_val = TMR_W'((32'(len_q) + TX_OVH_BYTES) * 8 * CYC_PER_BIT - 1);
         RS_TXACK:           tmr_val = TMR_W'(ACK_CYC - 1);
         default:            tmr_val = '0;
      endcase
   end

   assign tmr_load = (nxt != st);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= RS_OFF;
         cmd_err <= 1'b0;
         len_q   <= '0;
         lvl_q   <= '0;
      end else begin
         st      <= nxt;
         cmd_err <= illegal;
         if (nxt == RS_TXCAL && st != RS_TXCAL) begin
            len_q <= frame_len;
            lvl_q <= pwr_level;
         end
         if (nxt == RS_TXACK && st != RS_TXACK) lvl_q <= pwr_level;
      end
   end

   rps_dwell_timer #(.W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   rps_current_lut #(.SUPPLY_DV(SUPPLY_DV), .PWR_W(PWR_W)) u_lut (
      .st  (st),
      .lvl (lvl_q),
      .cur (cur_code),
      .pwr (pwr_code)
   );

   rps_energy_acc #(.ACC_W(ACC_W), .IN_W(CUR_W), .SATURATE(ENERGY_SAT)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (energy_clr),
      .add   (cur_code),
      .acc   (energy)
   );

   assign state_o = st;

   // leaving power-down only ever goes to start-up (R2)
   assert_off_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == RS_OFF && st != RS_OFF) |-> (st == RS_XOSC));

   // frame transmit ends in listening, or idle when forced off (R4)
   assert_txfrm_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == RS_TXFRM && st != RS_TXFRM) |-> (st == RS_LISTEN || st == RS_IDLE));

   // acknowledge transmit is reached only from frame receive (R5)
   assert_ack_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) != RS_TXACK && st == RS_TXACK) |-> ($past(st) == RS_RXFRM));

   // off outside power-down lands in idle (R6)
   assert_off_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd) == 3'(CMD_OFF) && $past(st) != RS_OFF) |-> (st == RS_IDLE));

   // error pulse always follows a nonzero command (R8)
   assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> ($past(cmd) != 3'd0));

endmodule

// File: tb/rf_power_seq_test.sv
module rf_power_seq_test;

   localparam int CPB   = 2;
   localparam int BPS   = 4;
   localparam int XOSC  = 40;
   localparam int ACCW  = 24;
   localparam int CAL   = 12 * BPS * CPB;
   localparam int ACK   = 88 * CPB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd = 3'd0;
   logic        xosc_stable = 1'b0;
   logic        cca_clear = 1'b0;
   logic [6:0]  frame_len = 7'd0;
   logic [2:0]  pwr_level = 3'd0;
   logic        rx_start = 1'b0;
   logic        rx_end = 1'b0;
   logic        rx_ack_req = 1'b0;
   logic        rx_addr_fail = 1'b0;
   logic        energy_clr = 1'b0;
   logic [3:0]  state_o;
   logic [17:0] cur_code;
   logic [22:0] pwr_code;
   logic [ACCW-1:0] energy;
   logic        cmd_err;

   int total = 0;
   int fails = 0;

   always #2 clk = ~clk;

   rf_power_seq #(
      .CYC_PER_BIT(CPB), .BITS_PER_SYM(BPS), .XOSC_CYC(XOSC),
      .LEN_W(7), .ACC_W(ACCW), .SUPPLY_DV(30)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .xosc_stable(xosc_stable),
      .cca_clear(cca_clear), .frame_len(frame_len), .pwr_level(pwr_level),
      .rx_start(rx_start), .rx_end(rx_end), .rx_ack_req(rx_ack_req),
      .rx_addr_fail(rx_addr_fail), .energy_clr(energy_clr),
      .state_o(state_o), .cur_code(cur_code), .pwr_code(pwr_code),
      .energy(energy), .cmd_err(cmd_err)
   );

   function automatic longint tx_i(input int lvl);
      longint t [8] = '{174000, 165000, 152000, 139000, 125000, 112000, 99000, 85000};
      return t[lvl];
   endfunction

   task automatic tick(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] c);
      cmd = c;
      tick();
      cmd = 3'd0;
   endtask

   task automatic dwell(input string tag, input int n, input int here, input int next);
      tick(n - 1);
      chk(tag, 64'(state_o), 64'(here));
      tick();
      chk(tag, 64'(state_o), 64'(next));
   endtask

   task automatic energy_win(input string tag, input int n, input longint expv);
      energy_clr = 1'b1;
      tick();
      energy_clr = 1'b0;
      chk(tag, 64'(energy), 64'd0);
      tick(n);
      chk(tag, 64'(energy), 64'(expv));
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 state", 64'(state_o), 0);
      chk("R1 energy", 64'(energy), 0);
      chk("R1 err", 64'(cmd_err), 0);
      chk("R9 sleep current", 64'(cur_code), 200);
      chk("R11 sleep power", 64'(pwr_code), 6000);

      // R8 sweep of illegal codes in power-down (code 6 covers R6 too)
      for (int k = 2; k < 8; k++) begin
         issue(3'(k));
         chk("R8 state held", 64'(state_o), 0);
         chk("R8 err pulse", 64'(cmd_err), 1);
         tick();
         chk("R8 err clears", 64'(cmd_err), 0);
      end
      issue(3'd0);
      chk("R8 no-op no err", 64'(cmd_err), 0);

      energy_win("R12 sleep charge", 10, 2000);

      // R2 wake, full oscillator wait
      issue(3'd1);
      chk("R2 start-up", 64'(state_o), 1);
      chk("R9 start-up current", 64'(cur_code), 4260);
      dwell("R2 start-up dwell", XOSC, 1, 2);

      // R3 receive calibration
      issue(3'd3);
      chk("R9 rx cal current", 64'(cur_code), 188000);
      dwell("R3 rx cal dwell", CAL, 3, 4);
      issue(3'd3);
      chk("R8 rx in listen state", 64'(state_o), 4);
      chk("R8 rx in listen err", 64'(cmd_err), 1);
      energy_win("R12 listen charge", 25, 25 * 4260);

      // R4 channel busy: no move, no error
      cca_clear = 1'b0;
      issue(3'd5);
      chk("R4 cca busy state", 64'(state_o), 4);
      chk("R4 cca busy err", 64'(cmd_err), 0);

      // R4/R10 frame lengths, inputs changed after capture
      for (int j = 0; j < 3; j++) begin
         int len;
         len = (j == 0) ? 0 : ((j == 1) ? 5 : 127);
         frame_len = 7'(len);
         pwr_level = 3'(7 - j);
         cca_clear = 1'b1;
         issue(3'd5);
         cca_clear = 1'b0;
         frame_len = 7'd60;
         pwr_level = 3'd0;
         chk("R4 tx cal entry", 64'(state_o), 6);
         chk("R10 captured level", 64'(cur_code), 64'(tx_i(7 - j)));
         chk("R11 tx power", 64'(pwr_code), 64'(tx_i(7 - j) * 30));
         dwell("R4 tx cal dwell", CAL, 6, 7);
         dwell("R4 frame dwell", (len + 6) * 8 * CPB, 7, 4);
      end

      // R8 command while busy
      issue(3'd4);
      issue(3'd3);
      chk("R8 busy state", 64'(state_o), 6);
      chk("R8 busy err", 64'(cmd_err), 1);
      // R6 off cuts calibration short
      tick(5);
      issue(3'd6);
      chk("R6 off aborts cal", 64'(state_o), 2);

      // R10 sweep of all levels from idle
      for (int l = 0; l < 8; l++) begin
         pwr_level = 3'(l);
         issue(3'd4);
         chk("R10 level current", 64'(cur_code), 64'(tx_i(l)));
         issue(3'd6);
         chk("R6 back to idle", 64'(state_o), 2);
      end

      // R5 receive paths
      issue(3'd3);
      tick(CAL);
      chk("R3 listen again", 64'(state_o), 4);
      rx_start = 1'b1; tick(); rx_start = 1'b0;
      chk("R5 frame receive", 64'(state_o), 5);
      chk("R9 rx frame current", 64'(cur_code), 188000);
      energy_win("R12 saturate", 100, (64'd1 << ACCW) - 1);
      rx_addr_fail = 1'b1; tick(); rx_addr_fail = 1'b0;
      chk("R5 address reject", 64'(state_o), 4);
      rx_start = 1'b1; tick(); rx_start = 1'b0;
      rx_end = 1'b1; tick(); rx_end = 1'b0;
      chk("R5 end without ack", 64'(state_o), 4);
      rx_start = 1'b1; tick(); rx_start = 1'b0;
      pwr_level = 3'd1;
      rx_end = 1'b1; rx_ack_req = 1'b1; tick();
      rx_end = 1'b0; rx_ack_req = 1'b0; pwr_level = 3'd6;
      chk("R5 ack entry", 64'(state_o), 8);
      chk("R10 ack level", 64'(cur_code), 165000);
      dwell("R5 ack dwell", ACK, 8, 4);

      // R6 off from listening, R7 sleep, R2 early stable
      issue(3'd6);
      chk("R6 listen off", 64'(state_o), 2);
      issue(3'd2);
      chk("R7 sleep", 64'(state_o), 0);
      issue(3'd1);
      tick(4);
      chk("R2 still waiting", 64'(state_o), 1);
      xosc_stable = 1'b1; tick(); xosc_stable = 1'b0;
      chk("R2 early ready", 64'(state_o), 2);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(4 * 150000);
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule